// File: doc/BRIEF.md
# Single-Level Paged Address Translator

The translator sits in series between a processor's 24-bit address bus and memory. Each logical address is split into a high segment number and a low page index. The segment number selects one entry of an internal table. That entry supplies the upper physical address bits together with a few attribute bits. The page index is copied straight through, so memory is mapped in fixed 8 KB pages.

Every cycle that the processor opens with its logical strobe costs one lookup clock. The translator then either raises the physical strobe toward memory or, if the entry's attributes forbid the access, raises a fault and leaves memory untouched. The function-code inputs tell the translator whether the access comes from user or supervisor code, and the read/write line tells it whether the access may alter memory. The memory acknowledge is handed back to the processor without change.

System software fills the table through a simple write port. A table write only takes effect while the bus is quiet.

Top module: `pageXlate`

## Requirements
- R1: After reset, physStrobe and fault are low and every table entry is invalid, so any access faults until its entry is loaded.
- R2: For a permitted access, physAddr[23:13] equals the selected entry's page field (entry bits 10..0) and physAddr[12:0] equals logAddr[12:0]; the entry is selected by logAddr[23:13].
- R3: physStrobe rises at the second rising clock edge at which logStrobe is sampled high (one clock of lookup delay), and only for a permitted access.
- R4: An access whose entry has its valid bit (entry bit 14) clear raises fault instead of physStrobe.
- R5: A user access (fc[2]=0) to an entry whose user-allowed bit (entry bit 13) is clear raises fault; supervisor accesses (fc[2]=1) ignore that bit.
- R6: A write access (rdWr=0; rdWr=1 means read) to an entry whose write-allowed bit (entry bit 12) is clear raises fault.
- R7: fault and physStrobe are never high together, and a fault stays high until logStrobe drops.
- R8: physStrobe and fault both go low at the first rising edge at which logStrobe is sampled low.
- R9: cpuAck follows memAck combinationally at all times.
- R10: A table write (tblWe sampled high, writing tblData to entry tblIdx) is ignored while logStrobe is high or a translated cycle is in progress, and takes effect otherwise.
- R11: For a permitted access, cacheInh equals the entry's cache-inhibit bit (entry bit 11).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| logAddr | input | 24 | Logical address from the processor |
| logStrobe | input | 1 | Logical address strobe, active high |
| fc | input | 3 | Function code; bit 2 high means supervisor |
| rdWr | input | 1 | 1 = read, 0 = write |
| physAddr | output | 24 | Translated physical address |
| physStrobe | output | 1 | Physical address strobe toward memory |
| cacheInh | output | 1 | Cache-inhibit mark of the current page |
| memAck | input | 1 | Acknowledge from memory |
| cpuAck | output | 1 | Acknowledge returned to the processor |
| tblWe | input | 1 | Table write enable |
| tblIdx | input | 11 | Table entry index to write |
| tblData | input | 15 | Entry: bit 14 valid, 13 user-allowed, 12 write-allowed, 11 cache-inhibit, 10..0 page |
| fault | output | 1 | Access violation indication |

## Verification
On every cycle the assertions check that fault and physStrobe exclude each other, that physStrobe only rises after a strobe that was already high, that both outputs clear one edge after the strobe drops, that the page offset passes through and holds steady during a cycle, and that the acknowledge is forwarded. Only the bench's scenarios can show that the right table entry was chosen, that each protection bit is decoded as specified against the function code and direction, and that writes made during a busy cycle really leave the table unchanged. Those scenarios mix directed boundary entries (index 0, index 2047, all-ones page) with seeded random loads and accesses.

// File: rtl/xlatePkg.sv
`timescale 1ns/1ps
package xlatePkg;
  localparam int OFF_W_D = 13;
  localparam int SEG_W_D = 11;
  localparam int PG_W_D  = 11;

  typedef struct packed {
    logic captureEn;   // latch logical request and read table
    logic issueEn;     // load physical address register
    logic tblWrEn;     // commit a table write
  } ctrlStrb_t;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_LOOKUP = 2'd1,
    ST_ACTIVE = 2'd2,
    ST_FAULT  = 2'd3
  } xlState_t;
endpackage

// File: rtl/xlateData.sv
`timescale 1ns/1ps
module xlateData
  import xlatePkg::*;
#(
  parameter int OFF_W = OFF_W_D,
  parameter int SEG_W = SEG_W_D,
  parameter int PG_W  = PG_W_D,
  localparam int LA_W  = OFF_W + SEG_W,
  localparam int PA_W  = OFF_W + PG_W,
  localparam int ENT_W = PG_W + 4,
  localparam int DEPTH = 1 << SEG_W
) (
  input  logic             clk,
  input  logic             rstN,
  input  ctrlStrb_t        strb,
  input  logic [LA_W-1:0]  logAddr,
  input  logic [2:0]       fc,
  input  logic             rdWr,
  input  logic [SEG_W-1:0] tblIdx,
  input  logic [ENT_W-1:0] tblData,
  output logic             permitOk,
  output logic [PA_W-1:0]  physAddr,
  output logic             cacheInh
);
  localparam int V_BIT = PG_W + 3;
  localparam int U_BIT = PG_W + 2;
  localparam int W_BIT = PG_W + 1;
  localparam int C_BIT = PG_W;

  logic [ENT_W-2:0] attrMem [DEPTH];
  logic [DEPTH-1:0] validVec;
  logic [ENT_W-2:0] rdEntry;
  logic             rdValid;
  logic [OFF_W-1:0] offReg;
  logic             superReg;
  logic             readReg;

  always_ff @(posedge clk) begin
    if (strb.tblWrEn) attrMem[tblIdx] <= tblData[ENT_W-2:0];
    if (strb.captureEn) rdEntry <= attrMem[logAddr[LA_W-1:OFF_W]];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      validVec <= '0;
      rdValid  <= 1'b0;
      offReg   <= '0;
      superReg <= 1'b0;
      readReg  <= 1'b1;
      physAddr <= '0;
      cacheInh <= 1'b0;
    end else begin
      if (strb.tblWrEn) validVec[tblIdx] <= tblData[V_BIT];
      if (strb.captureEn) begin
        rdValid  <= validVec[logAddr[LA_W-1:OFF_W]];
        offReg   <= logAddr[OFF_W-1:0];
        superReg <= fc[2];
        readReg  <= rdWr;
      end
      if (strb.issueEn) begin
        physAddr <= {rdEntry[PG_W-1:0], offReg};
        cacheInh <= rdEntry[C_BIT];
      end
    end
  end

  always_comb begin
    permitOk = rdValid;
    if (!superReg && !rdEntry[U_BIT]) permitOk = 1'b0;
    if (!readReg && !rdEntry[W_BIT])  permitOk = 1'b0;
  end
endmodule

// File: rtl/xlateCtrl.sv
`timescale 1ns/1ps
module xlateCtrl
  import xlatePkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      logStrobe,
  input  logic      tblWe,
  input  logic      permitOk,
  output ctrlStrb_t strb,
  output logic      physStrobe,
  output logic      fault
);
  xlState_t state;

  always_comb begin
    strb.captureEn = (state == ST_IDLE) && logStrobe;
    strb.issueEn   = (state == ST_LOOKUP) && logStrobe && permitOk;
    strb.tblWrEn   = (state == ST_IDLE) && !logStrobe && tblWe;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state      <= ST_IDLE;
      physStrobe <= 1'b0;
      fault      <= 1'b0;
    end else begin
      unique case (state)
        ST_IDLE: if (logStrobe) state <= ST_LOOKUP;
        ST_LOOKUP: begin
          if (!logStrobe) state <= ST_IDLE;
          else if (permitOk) begin
            state      <= ST_ACTIVE;
            physStrobe <= 1'b1;
          end else begin
            state <= ST_FAULT;
            fault <= 1'b1;
          end
        end
        ST_ACTIVE, ST_FAULT: begin
          if (!logStrobe) begin
            state      <= ST_IDLE;
            physStrobe <= 1'b0;
            fault      <= 1'b0;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/pageXlate.sv
`timescale 1ns/1ps
module pageXlate
  import xlatePkg::*;
#(
  parameter int OFF_W = OFF_W_D,
  parameter int SEG_W = SEG_W_D,
  parameter int PG_W  = PG_W_D,
  localparam int LA_W  = OFF_W + SEG_W,
  localparam int PA_W  = OFF_W + PG_W,
  localparam int ENT_W = PG_W + 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [LA_W-1:0]  logAddr,
  input  logic             logStrobe,
  input  logic [2:0]       fc,
  input  logic             rdWr,
  output logic [PA_W-1:0]  physAddr,
  output logic             physStrobe,
  output logic             cacheInh,
  input  logic             memAck,
  output logic             cpuAck,
  input  logic             tblWe,
  input  logic [SEG_W-1:0] tblIdx,
  input  logic [ENT_W-1:0] tblData,
  output logic             fault
);
  ctrlStrb_t strb;
  logic      permitOk;

  assign cpuAck = memAck;

  xlateCtrl u_ctrl (
    .clk(clk), .rstN(rstN), .logStrobe(logStrobe), .tblWe(tblWe),
    .permitOk(permitOk), .strb(strb), .physStrobe(physStrobe), .fault(fault)
  );

  xlateData #(.OFF_W(OFF_W), .SEG_W(SEG_W), .PG_W(PG_W)) u_data (
    .clk(clk), .rstN(rstN), .strb(strb), .logAddr(logAddr), .fc(fc),
    .rdWr(rdWr), .tblIdx(tblIdx), .tblData(tblData), .permitOk(permitOk),
    .physAddr(physAddr), .cacheInh(cacheInh)
  );
endmodule

// File: rtl/pageXlateChk.sv
`timescale 1ns/1ps
module pageXlateChk #(
  parameter int OFF_W = 13,
  parameter int LA_W  = 24,
  parameter int PA_W  = 24
) (
  input logic            clk,
  input logic            rstN,
  input logic            logStrobe,
  input logic [LA_W-1:0] logAddr,
  input logic            physStrobe,
  input logic [PA_W-1:0] physAddr,
  input logic            fault,
  input logic            memAck,
  input logic            cpuAck
);
  // R7
  excl_out_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(physStrobe && fault));

  // R3
  strobe_delay_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(physStrobe) |-> $past(logStrobe));

  // R8
  release_chk: assert property (@(posedge clk) disable iff (!rstN)
    !logStrobe |=> (!physStrobe && !fault));

  // R7
  fault_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (fault && logStrobe) |=> fault);

  // R2
  offset_pass_chk: assert property (@(posedge clk) disable iff (!rstN)
    (physStrobe && logStrobe) |-> (physAddr[OFF_W-1:0] == logAddr[OFF_W-1:0]));

  // R2
  addr_steady_chk: assert property (@(posedge clk) disable iff (!rstN)
    (physStrobe && $past(physStrobe)) |-> $stable(physAddr));

  // R9
  always_comb begin
    ack_pass_chk: assert (cpuAck == memAck);
  end
endmodule

bind pageXlate pageXlateChk #(.OFF_W(OFF_W), .LA_W(LA_W), .PA_W(PA_W)) u_chk (
  .clk(clk), .rstN(rstN), .logStrobe(logStrobe), .logAddr(logAddr),
  .physStrobe(physStrobe), .physAddr(physAddr), .fault(fault),
  .memAck(memAck), .cpuAck(cpuAck)
);

// File: tb/sim_pageXlate.sv
`timescale 1ns/1ps
module sim_pageXlate;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [23:0] logAddr = '0;
  logic        logStrobe = 1'b0;
  logic [2:0]  fc = 3'b110;
  logic        rdWr = 1'b1;
  logic [23:0] physAddr;
  logic        physStrobe;
  logic        cacheInh;
  logic        memAck = 1'b0;
  logic        cpuAck;
  logic        tblWe = 1'b0;
  logic [10:0] tblIdx = '0;
  logic [14:0] tblData = '0;
  logic        fault;

  int unsigned nChecks = 0;
  int unsigned nFails = 0;
  logic [14:0] model [2048];
  bit          finished = 0;

  always #5 clk = ~clk;

  pageXlate u0 (
    .clk(clk), .rstN(rstN), .logAddr(logAddr), .logStrobe(logStrobe),
    .fc(fc), .rdWr(rdWr), .physAddr(physAddr), .physStrobe(physStrobe),
    .cacheInh(cacheInh), .memAck(memAck), .cpuAck(cpuAck), .tblWe(tblWe),
    .tblIdx(tblIdx), .tblData(tblData), .fault(fault)
  );

  task automatic check(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic bit expFault(input logic [14:0] ent, input logic [2:0] f,
                                  input logic rw);
    return !ent[14] || (!f[2] && !ent[13]) || (!rw && !ent[12]);
  endfunction

  task automatic loadEntry(input logic [10:0] idx, input logic [14:0] val);
    @(negedge clk);
    tblWe = 1'b1; tblIdx = idx; tblData = val;
    @(negedge clk);
    tblWe = 1'b0;
    model[idx] = val;
  endtask

  // one full access; optionally attempts a table write while busy
  task automatic access(input logic [23:0] la, input logic [2:0] f, input logic rw,
                        input bit tryWrite, input logic [10:0] wIdx,
                        input logic [14:0] wVal);
    logic [14:0] ent;
    bit ef;
    ent = model[la[23:13]];
    ef = expFault(ent, f, rw);
    @(negedge clk);
    logAddr = la; fc = f; rdWr = rw; logStrobe = 1'b1;
    @(negedge clk);
    check(physStrobe == 1'b0 && fault == 1'b0, "R3 lookup delay", {30'd0, physStrobe, fault}, 32'd0);
    @(negedge clk);
    if (ef) begin
      check(fault == 1'b1 && physStrobe == 1'b0, "R4 R5 R6 R7 fault", {30'd0, physStrobe, fault}, 32'd1);
    end else begin
      check(physStrobe == 1'b1 && fault == 1'b0, "R3 strobe", {30'd0, physStrobe, fault}, 32'd2);
      check(physAddr == {ent[10:0], la[12:0]}, "R2 address", {8'd0, physAddr}, {8'd0, ent[10:0], la[12:0]});
      check(cacheInh == ent[11], "R11 cache mark", {31'd0, cacheInh}, {31'd0, ent[11]});
      memAck = 1'b1;
      #1;
      check(cpuAck == 1'b1, "R9 ack high", {31'd0, cpuAck}, 32'd1);
      memAck = 1'b0;
      #1;
      check(cpuAck == 1'b0, "R9 ack low", {31'd0, cpuAck}, 32'd0);
    end
    if (tryWrite) begin
      tblWe = 1'b1; tblIdx = wIdx; tblData = wVal;
      @(negedge clk);
      tblWe = 1'b0;
      check(fault == ef && physStrobe == !ef, "R7 hold", {30'd0, physStrobe, fault}, {30'd0, !ef, ef});
    end
    logStrobe = 1'b0;
    @(negedge clk);
    check(physStrobe == 1'b0 && fault == 1'b0, "R8 release", {30'd0, physStrobe, fault}, 32'd0);
  endtask

  initial begin
    #2000000;
    if (!finished) begin
      nChecks++; nFails++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
      $finish;
    end
  end

  initial begin
    int unsigned seedDummy;
    logic [10:0] loaded [64];
    seedDummy = $urandom(32'd424242);
    for (int i = 0; i < 2048; i++) model[i] = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check(physStrobe == 1'b0 && fault == 1'b0, "R1 reset outputs", {30'd0, physStrobe, fault}, 32'd0);
    // R1: unloaded entry must fault
    access(24'h12_3456, 3'b110, 1'b1, 0, '0, '0);
    access(24'hFF_FFFF, 3'b101, 1'b1, 0, '0, '0);

    // directed entries: bit14 valid, 13 user, 12 write, 11 cache, 10..0 page
    loadEntry(11'd0,    15'b1_1_1_0_11111111111);
    loadEntry(11'd2047, 15'b1_1_1_1_00000000001);
    loadEntry(11'd5,    15'b1_0_1_0_00000101010); // supervisor only
    loadEntry(11'd6,    15'b1_1_0_1_00000111000); // read only
    loadEntry(11'd7,    15'b0_1_1_0_00001111111); // invalid

    access(24'h00_1FFF, 3'b001, 1'b0, 0, '0, '0);          // R2 max page, user write
    access(24'hFF_E000, 3'b010, 1'b1, 0, '0, '0);          // R11 cache mark set
    access({11'd5, 13'h0AB}, 3'b001, 1'b1, 0, '0, '0);     // R5 user denied
    access({11'd5, 13'h0AB}, 3'b101, 1'b0, 0, '0, '0);     // R5 supervisor ok
    access({11'd6, 13'h100}, 3'b101, 1'b0, 0, '0, '0);     // R6 write denied
    access({11'd6, 13'h100}, 3'b010, 1'b1, 0, '0, '0);     // R6 read ok
    access({11'd7, 13'h000}, 3'b110, 1'b1, 0, '0, '0);     // R4 invalid

    // R10: write during a busy cycle must be ignored
    access({11'd0, 13'h10}, 3'b110, 1'b1, 1, 11'd0, 15'b0_0_0_0_00000000000);
    access({11'd0, 13'h20}, 3'b110, 1'b1, 0, '0, '0);      // R10 entry 0 still intact
    access({11'd7, 13'h30}, 3'b110, 1'b1, 1, 11'd7, 15'b1_1_1_0_00000000011);
    access({11'd7, 13'h30}, 3'b110, 1'b1, 0, '0, '0);      // R10 entry 7 still invalid
    loadEntry(11'd7, 15'b1_1_1_0_00000000011);             // R10 idle write takes effect
    access({11'd7, 13'h31}, 3'b001, 1'b0, 0, '0, '0);

    // random loads and accesses
    for (int i = 0; i < 64; i++) begin
      loaded[i] = 11'($urandom_range(0, 2047));
      loadEntry(loaded[i], 15'($urandom));
    end
    for (int i = 0; i < 300; i++) begin
      logic [10:0] seg;
      logic [23:0] la;
      if ($urandom_range(0, 3) != 0) seg = loaded[$urandom_range(0, 63)];
      else seg = 11'($urandom);
      la = {seg, 13'($urandom)};
      access(la, 3'($urandom), 1'($urandom), ($urandom_range(0, 7) == 0),
             11'($urandom), 15'($urandom));
    end

    finished = 1;
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end
endmodule